// File: doc/BRIEF.md
# Trigger Frame Aggregator

The aggregator gathers per-crossing trigger words from a set of front-end sources and turns them into one frame per bunch crossing, ready for a serial transceiver. During a crossing period any source may present a 16-bit word on any cycle, with a valid flag. Accepted words are stored in arrival order. When several sources are valid in the same cycle, the lower source index is stored first. At most twelve words are kept per crossing, and any word beyond that is discarded and marks the crossing as overflowed.

A one-cycle crossing strobe closes the collection and starts the frame for the crossing just closed. In the cycle after the strobe the output carries a header word holding a 16-bit crossing number. The stored data words follow, one per cycle. Idle words then fill every slot until the next header. Each output word has a 2-bit type tag, so the transceiver side can tell idle, header and data words apart. The same design serves six sources in the base configuration and eight in the extended one, through a parameter.

Top module: `trig_frame_agg`

## Requirements
- R1: After reset the output is idle (tag 00, word 0) and the overflow flag is low until the first strobe. The first frame's header carries crossing number 0.
- R2: In the cycle after each strobe the output is a header (tag 01). Its word is the crossing number, a 16-bit count that advances by one per strobe. A header appears in no other cycle.
- R3: Data words (tag 10) follow the header on consecutive cycles, in the order they were accepted. Words from one cycle are ordered by ascending source index.
- R4: A crossing keeps at most 12 words and drops any later ones. If a word was dropped, the overflow output is high from that crossing's header until the next header, and is low otherwise.
- R5: Once the stored words of the frame are sent, the output is idle (tag 00, word 0) until the next header.
- R6: Words that are valid in the same cycle as the strobe belong to the next crossing, not the one being closed.
- R7: A source with no valid word contributes nothing. A crossing with no words gives a header followed only by idle words.
- R8: A strobe that arrives before a frame is finished cuts that frame short. The next cycle carries the new header.
- R9: The tag value 11 never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xing_i | input | 1 | One-cycle strobe that ends a crossing |
| src_valid_i | input | N_SRC | Per-source word valid |
| src_data_i | input | N_SRC*16 | Per-source words, source i in bits [16i+15:16i] |
| word_o | output | 16 | Outgoing frame word |
| tag_o | output | 2 | Word type: 00 idle, 01 header, 10 data |
| overflow_o | output | 1 | The crossing being sent lost words |

## Verification
The assertions check, on every cycle, the rules that depend only on local timing:
- a header appears exactly one cycle after a strobe, and in no other cycle;
- the crossing number advances by one per strobe;
- a frame never carries more than twelve data words;
- the overflow flag stays fixed within a frame;
- a full or overflowed collection stays that way until the strobe.

Only the bench scenarios can show that the right words arrive in the right order. This covers words from several sources in the same cycle, words arriving on the strobe cycle, and frames cut short by an early strobe. The bench compares every output cycle with a reference model derived from the requirements. The sweep covers all 256 source masks.

// File: rtl/trig_agg_pkg.sv
package trig_agg_pkg;
  typedef enum logic [1:0] {
    TAG_IDLE = 2'b00,
    TAG_HDR  = 2'b01,
    TAG_DATA = 2'b10
  } tag_e;
endpackage

// File: rtl/trig_xing_ctr.sv
module trig_xing_ctr #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xing_i,
  output logic [WORD_W-1:0] xnum_o
);
  logic [WORD_W-1:0] xnum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     xnum_q <= '0;
    else if (xing_i) xnum_q <= xnum_q + 1'b1;
  end

  assign xnum_o = xnum_q;

  // R2
  xnum_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xing_i |=> xnum_q == $past(xnum_q) + 1'b1);
endmodule

// File: rtl/trig_collect.sv
module trig_collect #(
  parameter int N_SRC     = 8,
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 12,
  localparam int CNT_W    = $clog2(MAX_WORDS + N_SRC + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 xing_i,
  input  logic [N_SRC-1:0]                     valid_i,
  input  logic [N_SRC*WORD_W-1:0]              data_i,
  output logic [MAX_WORDS-1:0][WORD_W-1:0]     buf_o,
  output logic [CNT_W-1:0]                     cnt_o,
  output logic                                 ovf_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_WORDS);

  logic [MAX_WORDS-1:0][WORD_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, base, total;
  logic [CNT_W-1:0] pos [N_SRC];
  logic             ovf_q, ovf_d;

  // A strobe cycle restarts the buffer, so its own words land from slot 0
  always_comb begin
    logic [CNT_W-1:0] acc;
    base = xing_i ? '0 : cnt_q;
    acc  = base;
    for (int i = 0; i < N_SRC; i++) begin
      pos[i] = acc;
      acc    = acc + CNT_W'(valid_i[i]);
    end
    total = acc;
    cnt_d = (total > MAX_C) ? MAX_C : total;
    ovf_d = (ovf_q & ~xing_i) | (total > MAX_C);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      for (int i = 0; i < N_SRC; i++) begin
        if (valid_i[i] && pos[i] < MAX_C)
          buf_q[pos[i][IDX_W-1:0]] <= data_i[i*WORD_W +: WORD_W];
      end
    end
  end

  assign buf_o = buf_q;
  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !xing_i |=> ovf_q);
  // R4
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xing_i && cnt_q == MAX_C |=> cnt_q == MAX_C);
endmodule

// File: rtl/trig_frame_seq.sv
module trig_frame_seq
  import trig_agg_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 12,
  parameter int CNT_W     = 5,
  localparam int SLOT_W   = $clog2(MAX_WORDS + 2),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             xing_i,
  input  logic [WORD_W-1:0]                xnum_i,
  input  logic [MAX_WORDS-1:0][WORD_W-1:0] buf_i,
  input  logic [CNT_W-1:0]                 cnt_i,
  input  logic                             ovf_i,
  output logic [WORD_W-1:0]                word_o,
  output logic [1:0]                       tag_o,
  output logic                             overflow_o
);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(MAX_WORDS + 1);
  localparam logic [CNT_W-1:0]  MAX_C    = CNT_W'(MAX_WORDS);

  logic [MAX_WORDS-1:0][WORD_W-1:0] tx_buf_q;
  logic [CNT_W-1:0]  tx_cnt_q;
  logic              tx_ovf_q, active_q;
  logic [WORD_W-1:0] hdr_q;
  logic [SLOT_W-1:0] slot_q, slot_m1;
  tag_e              tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q <= '0;
      tx_cnt_q <= '0;
      tx_ovf_q <= 1'b0;
      active_q <= 1'b0;
      hdr_q    <= '0;
      slot_q   <= '0;
    end else if (xing_i) begin
      tx_buf_q <= buf_i;
      tx_cnt_q <= cnt_i;
      tx_ovf_q <= ovf_i;
      hdr_q    <= xnum_i;
      active_q <= 1'b1;
      slot_q   <= '0;
    end else if (active_q && slot_q != SLOT_END) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_m1 = slot_q - 1'b1;

  always_comb begin
    tag    = TAG_IDLE;
    word_o = '0;
    if (active_q) begin
      if (slot_q == '0) begin
        tag    = TAG_HDR;
        word_o = hdr_q;
      end else if (int'(slot_q) <= int'(tx_cnt_q)) begin
        tag    = TAG_DATA;
        word_o = tx_buf_q[IDX_W'(slot_m1)];
      end
    end
  end

  assign tag_o      = tag;
  assign overflow_o = tx_ovf_q;

  // checker state
  logic             past_xing_q;
  logic [CNT_W-1:0] dcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_xing_q <= 1'b0;
      dcnt_q      <= '0;
    end else begin
      past_xing_q <= xing_i;
      if (tag == TAG_HDR)       dcnt_q <= '0;
      else if (tag == TAG_DATA) dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // R2
  hdr_after_xing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_xing_q |-> tag_o == TAG_HDR);
  // R2
  hdr_only_after_xing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o == TAG_HDR |-> past_xing_q);
  // R4
  data_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o == TAG_DATA |-> dcnt_q < MAX_C);
  // R4
  ovf_frame_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xing_i |=> $stable(overflow_o));
endmodule

// File: rtl/trig_frame_agg.sv
module trig_frame_agg #(
  parameter int N_SRC     = 8,
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 12,
  localparam int CNT_W    = $clog2(MAX_WORDS + N_SRC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xing_i,
  input  logic [N_SRC-1:0]        src_valid_i,
  input  logic [N_SRC*WORD_W-1:0] src_data_i,
  output logic [WORD_W-1:0]       word_o,
  output logic [1:0]              tag_o,
  output logic                    overflow_o
);
  logic [WORD_W-1:0]                xnum;
  logic [MAX_WORDS-1:0][WORD_W-1:0] col_buf;
  logic [CNT_W-1:0]                 col_cnt;
  logic                             col_ovf;

  trig_xing_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xing_i (xing_i),
    .xnum_o (xnum)
  );

  trig_collect #(
    .N_SRC(N_SRC), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)
  ) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .xing_i  (xing_i),
    .valid_i (src_valid_i),
    .data_i  (src_data_i),
    .buf_o   (col_buf),
    .cnt_o   (col_cnt),
    .ovf_o   (col_ovf)
  );

  trig_frame_seq #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xing_i     (xing_i),
    .xnum_i     (xnum),
    .buf_i      (col_buf),
    .cnt_i      (col_cnt),
    .ovf_i      (col_ovf),
    .word_o     (word_o),
    .tag_o      (tag_o),
    .overflow_o (overflow_o)
  );
endmodule

// File: tb/trig_frame_agg_test.sv
`timescale 1ns/1ps
module trig_frame_agg_test;
  localparam int N = 8;
  localparam int W = 16;
  localparam int M = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xing = 1'b0;
  logic [N-1:0]   vld = '0;
  logic [N*W-1:0] dat = '0;
  logic [W-1:0] word;
  logic [1:0]   tag;
  logic         ovf;

  trig_frame_agg #(.N_SRC(N), .WORD_W(W), .MAX_WORDS(M)) uut (
    .clk_i(clk), .rst_ni(rst_n), .xing_i(xing), .src_valid_i(vld),
    .src_data_i(dat), .word_o(word), .tag_o(tag), .overflow_o(ovf)
  );

  always #2.5 clk = ~clk;

  int nchecks = 0, nfail = 0, tick = 0;
  bit done = 0, mon_en = 0;
  string scn = "R1 reset";

  task automatic chk(input bit ok, input string req, input string what,
                     input int actv, input int expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, scn, what, actv, expv);
    end
  endtask

  // Reference model from the requirements
  logic [W-1:0] c_w [M];
  logic [W-1:0] f_w [M];
  int c_cnt = 0, f_cnt = 0, slot = 0;
  bit c_ovf = 0, f_ovf = 0, act = 0;
  logic [W-1:0] xnum = '0, f_hdr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      c_cnt = 0; f_cnt = 0; slot = 0; c_ovf = 0; f_ovf = 0; act = 0;
      xnum = '0; f_hdr = '0;
    end else begin
      if (xing) begin
        f_w = c_w; f_cnt = c_cnt; f_ovf = c_ovf; f_hdr = xnum;
        xnum = xnum + 1'b1; slot = 0; act = 1; c_cnt = 0; c_ovf = 0;
      end else if (act && slot < M + 1) slot++;
      // R6: strobe-cycle words enter the fresh collection; R3 ascending index
      for (int i = 0; i < N; i++) begin
        if (vld[i]) begin
          if (c_cnt < M) begin c_w[c_cnt] = dat[i*W +: W]; c_cnt++; end
          else c_ovf = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      int et, ew;
      string req;
      et = 0; ew = 0;
      if (act) begin
        if (slot == 0) begin et = 1; ew = int'(f_hdr); end
        else if (slot <= f_cnt) begin et = 2; ew = int'(f_w[slot-1]); end
      end
      req = (et == 1) ? "R2" : (et == 2) ? "R3" : "R5";
      chk(tag == 2'(et), req, "tag", int'(tag), et);
      chk(word == W'(ew), req, "word", int'(word), ew);
      chk(ovf == f_ovf, "R4", "overflow", int'(ovf), int'(f_ovf));
      chk(tag !== 2'b11, "R9", "illegal tag", int'(tag), 0);
    end
  end

  task automatic cyc(input logic [N-1:0] m, input bit x);
    vld  = m;
    xing = x;
    for (int i = 0; i < N; i++) dat[i*W +: W] = {tick[11:0], 4'(i)};
    tick++;
    @(negedge clk);
  endtask

  task automatic crossing(input int period, input logic [N-1:0] m, input int n,
                          input logic [N-1:0] ms);
    for (int c = 0; c < period; c++) begin
      if (c == period - 1) cyc(ms, 1'b1);
      else cyc((c < n) ? m : '0, 1'b0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during and right after reset
    chk(tag == 2'b00, "R1", "reset tag", int'(tag), 0);
    chk(word == '0, "R1", "reset word", int'(word), 0);
    chk(ovf == 1'b0, "R1", "reset overflow", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;
    repeat (3) cyc('0, 1'b0);
    chk(tag == 2'b00 && word == '0, "R1", "idle before first strobe", int'(tag), 0);
    // R1: first header must be crossing 0 (model checks header value)
    scn = "R7 empty crossings";
    crossing(15, '0, 0, '0);
    crossing(15, '0, 0, '0);
    crossing(15, '0, 0, '0);
    // R3/R4: every source mask for two cycles, 0..16 words
    scn = "R3 R4 mask sweep";
    for (int m = 0; m < 256; m++) crossing(15, N'(m), 2, '0);
    scn = "R6 strobe-cycle words";
    for (int k = 0; k < 20; k++) crossing(15, N'(k * 29 + 3), 1, N'(k * 37 + 1));
    scn = "R4 heavy overflow";
    for (int k = 0; k < 4; k++) crossing(15, '1, 3, '1);
    scn = "R8 short crossings";
    for (int k = 0; k < 30; k++) crossing(5, N'(k * 91 + 7), 2, N'(k * 53));
    scn = "R7 flush";
    crossing(15, '0, 0, '0);
    crossing(15, '0, 0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule